// File: doc/BRIEF.md
# Dual-Phase Lock-In Demodulator

This block recovers the in-phase and quadrature content of a weak signal at a known reference frequency. Each valid cycle it takes one signed 14-bit ADC sample and two signed 14-bit reference samples, a sine and a cosine from an external locked oscillator. It forms two full-precision products. Each product drives its own first-order recursive low-pass stage that behaves like an RC smoother. The two filtered values are DC estimates that scale with the input amplitude at the reference frequency. They leave the block on separate ports.

Each stage computes `y = floor((b1*y_prev + a0*p) / 2^17)`. Here `p` is the mixer product, and `a0` and `b1` are unsigned 18-bit Q1.17 fractions that can change while the block runs. The stage state is 40 bits wide and saturates at its limits. In normal use the coefficients satisfy a0 + b1 = 1.0, and the time constant is set by b1. Both paths share a single input strobe and a single output strobe.

Top module: `lockin_demod`

## Requirements
- R1: While `rst` is high at a rising clock edge, both filter states and `out_valid` become 0 at that edge. This applies at start-up and also mid-run.
- R2: On an edge where `sample_valid` is high, the in-phase state becomes floor((b1*y + a0*(sample_in*ref_sin)) / 131072), computed from signed operands. `out_i` shows the new value from that edge on.
- R3: The quadrature state follows the same update using `ref_cos` in place of `ref_sin`, and is shown on `out_q`.
- R4: On an edge where `sample_valid` is low, both states and both outputs hold their values, whatever happens on the sample, reference and coefficient inputs.
- R5: `out_valid` is high for exactly the one cycle after each edge that accepts a sample, and is low otherwise. Back-to-back samples give a continuous high level.
- R6: An update result above 2^39-1 is stored as 2^39-1, and a result below -2^39 is stored as -2^39.
- R7: `coef_a0` and `coef_b1` are sampled only on accepting edges. A new pair takes effect from the next accepted sample and leaves the stored state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | The inputs on this cycle form one sample |
| sample_in | input | 14 | Signed ADC sample of the measured signal |
| ref_sin | input | 14 | Signed in-phase reference sample |
| ref_cos | input | 14 | Signed quadrature reference sample |
| coef_a0 | input | 18 | Unsigned Q1.17 input gain |
| coef_b1 | input | 18 | Unsigned Q1.17 feedback gain |
| out_valid | output | 1 | Pulses one cycle after each accepted sample |
| out_i | output | 40 | Signed in-phase DC estimate |
| out_q | output | 40 | Signed quadrature DC estimate |

## Verification
The embedded properties assume that the sample and reference inputs are stable two's-complement values on every clock edge and carry no unknown bits, because they reason about the sign of each product. They also assume that `rst` is a clean synchronous level.

The stimulus always drives every input to a defined value, changes inputs only on the falling clock edge, and holds `sample_valid` at a known level at all times. The stimulus also changes the coefficients during idle gaps, to show that they have no effect there.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
    localparam int SAMPLE_W = 14;
    localparam int COEF_W   = 18;
    localparam int FRAC_W   = 17;
    localparam int ACC_W    = 40;
    localparam int NUM_PATH = 2;
endpackage

// File: rtl/lockin_mixer.sv
module lockin_mixer #(
    parameter int SAMPLE_W = lockin_pkg::SAMPLE_W,
    localparam int PROD_W  = 2 * SAMPLE_W
) (
    input  logic signed [SAMPLE_W-1:0] sig_in,
    input  logic signed [SAMPLE_W-1:0] ref_in,
    output logic signed [PROD_W-1:0]   prod_out
);
    // Full-precision signed product; no rounding at this stage.
    always_comb begin
        prod_out = PROD_W'(sig_in) * PROD_W'(ref_in);
    end

    always_comb begin
        if ((sig_in == '0) || (ref_in == '0)) begin
            AST_ZERO_OPERAND: assert (prod_out == '0); // R2
        end
        if ((sig_in > 0) && (ref_in > 0)) begin
            AST_POSITIVE_PRODUCT: assert (prod_out > 0); // R3
        end
        if ((sig_in > 0) && (ref_in < 0)) begin
            AST_NEGATIVE_PRODUCT: assert (prod_out < 0); // R2
        end
    end
endmodule

// File: rtl/lockin_iir.sv
module lockin_iir #(
    parameter int IN_W    = 28,
    parameter int COEF_W  = lockin_pkg::COEF_W,
    parameter int FRAC_W  = lockin_pkg::FRAC_W,
    parameter int ACC_W   = lockin_pkg::ACC_W,
    localparam int SUM_W  = ACC_W + COEF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [IN_W-1:0]   x_in,
    input  logic        [COEF_W-1:0] a0,
    input  logic        [COEF_W-1:0] b1,
    output logic signed [ACC_W-1:0]  y_out
);
    typedef struct packed {
        logic signed [ACC_W-1:0] y;
    } iir_state_t;

    localparam logic signed [SUM_W-1:0] Y_MAX = SUM_W'({1'b0, {(ACC_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] Y_MIN = -Y_MAX - SUM_W'(1);

    iir_state_t st_d, st_q;

    logic signed [SUM_W-1:0] feed_fwd;
    logic signed [SUM_W-1:0] feed_back;
    logic signed [SUM_W-1:0] acc_sum;
    logic signed [SUM_W-1:0] acc_shift;

    always_comb begin
        feed_fwd  = $signed({{(SUM_W-COEF_W){1'b0}}, a0}) * SUM_W'(x_in);
        feed_back = $signed({{(SUM_W-COEF_W){1'b0}}, b1}) * SUM_W'(st_q.y);
        acc_sum   = feed_fwd + feed_back;
        acc_shift = acc_sum >>> FRAC_W;
        st_d      = st_q;
        if (rst) begin
            st_d.y = '0;
        end else if (en) begin
            if (acc_shift > Y_MAX) begin
                st_d.y = Y_MAX[ACC_W-1:0];
            end else if (acc_shift < Y_MIN) begin
                st_d.y = Y_MIN[ACC_W-1:0];
            end else begin
                st_d.y = acc_shift[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y_out = st_q.y;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(y_out)); // R4
    AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && x_in == '0 && y_out == '0) |=> (y_out == '0)); // R2
endmodule

// File: rtl/lockin_demod.sv
module lockin_demod #(
    parameter int SAMPLE_W = lockin_pkg::SAMPLE_W,
    parameter int COEF_W   = lockin_pkg::COEF_W,
    parameter int FRAC_W   = lockin_pkg::FRAC_W,
    parameter int ACC_W    = lockin_pkg::ACC_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic signed [SAMPLE_W-1:0] ref_sin,
    input  logic signed [SAMPLE_W-1:0] ref_cos,
    input  logic        [COEF_W-1:0]   coef_a0,
    input  logic        [COEF_W-1:0]   coef_b1,
    output logic                       out_valid,
    output logic signed [ACC_W-1:0]    out_i,
    output logic signed [ACC_W-1:0]    out_q
);
    localparam int PROD_W   = 2 * SAMPLE_W;
    localparam int NUM_PATH = lockin_pkg::NUM_PATH;

    typedef struct packed {
        logic vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic signed [SAMPLE_W-1:0] ref_sel [NUM_PATH];
    logic signed [PROD_W-1:0]   prod    [NUM_PATH];
    logic signed [ACC_W-1:0]    y_path  [NUM_PATH];

    assign ref_sel[0] = ref_sin;
    assign ref_sel[1] = ref_cos;

    for (genvar g = 0; g < NUM_PATH; g++) begin : g_path
        lockin_mixer #(.SAMPLE_W(SAMPLE_W)) i_mix (
            .sig_in   (sample_in),
            .ref_in   (ref_sel[g]),
            .prod_out (prod[g])
        );
        lockin_iir #(
            .IN_W   (PROD_W),
            .COEF_W (COEF_W),
            .FRAC_W (FRAC_W),
            .ACC_W  (ACC_W)
        ) i_iir (
            .clk   (clk),
            .rst   (rst),
            .en    (sample_valid),
            .x_in  (prod[g]),
            .a0    (coef_a0),
            .b1    (coef_b1),
            .y_out (y_path[g])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = rst ? 1'b0 : sample_valid;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign out_valid = ctl_q.vld;
    assign out_i     = y_path[0];
    assign out_q     = y_path[1];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> out_valid); // R5
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> !out_valid); // R5
    AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(out_i) && $stable(out_q))); // R4
endmodule

// File: tb/test_lockin_demod.sv
module test_lockin_demod;
    localparam int  FRAC = 17;
    localparam longint YMAX = (64'sd1 <<< 39) - 1;
    localparam longint YMIN = -(64'sd1 <<< 39);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_valid = 1'b0;
    logic signed [13:0] sample_in = '0, ref_sin = '0, ref_cos = '0;
    logic [17:0] coef_a0 = '0, coef_b1 = '0;
    logic out_valid;
    logic signed [39:0] out_i, out_q;

    int n_chk = 0, n_err = 0, cyc = 0;
    longint mi = 0, mq = 0;
    longint exp_q_i[$];
    longint exp_q_q[$];
    bit done = 0;

    always #2 clk = ~clk;

    lockin_demod i_lockin_demod (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
        .ref_sin(ref_sin), .ref_cos(ref_cos), .coef_a0(coef_a0), .coef_b1(coef_b1),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint step(longint y, longint x, longint r, longint a0, longint b1);
        longint s;
        s = (b1 * y + a0 * (x * r)) >>> FRAC;
        if (s > YMAX) s = YMAX;
        if (s < YMIN) s = YMIN;
        return s;
    endfunction

    task automatic drive(input int x, input int rs, input int rc);
        @(negedge clk);
        sample_in = 14'(x); ref_sin = 14'(rs); ref_cos = 14'(rc);
        sample_valid = 1'b1;
        mi = step(mi, x, rs, coef_a0, coef_b1);
        mq = step(mq, x, rc, coef_a0, coef_b1);
        exp_q_i.push_back(mi);
        exp_q_q.push_back(mq);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sample_valid = 1'b0;
            sample_in = 14'(k * 37 - 900); ref_sin = 14'(-k * 11); ref_cos = 14'(k * 5 + 3);
        end
    endtask

    // Monitor: one cycle after each accepted sample the results appear.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q_i.size() == 0) begin
                    check("R5 unexpected out_valid", 1, 0);
                end else begin
                    check("R2 out_i", out_i, exp_q_i.pop_front());
                    check("R3 out_q", out_q, exp_q_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 out_i", out_i, 0);
        check("R1 out_q", out_q, 0);
        @(negedge clk); rst = 1'b0;

        // Pass-through gain: a0 = 1.0, b1 = 0
        coef_a0 = 18'd131072; coef_b1 = 18'd0;
        drive(1000, 2000, -3000);
        drive(-8192, -8192, 8191);
        drive(8191, 0, 1);
        idle(2);
        check("R5 out_valid low when idle", out_valid, 0);

        // Smoothing a0 = b1 = 0.5, back-to-back samples
        coef_a0 = 18'd65536; coef_b1 = 18'd65536;
        for (int k = 0; k < 20; k++) drive(4000, 3000 - k * 100, -2500 + k * 50);
        @(negedge clk); sample_valid = 1'b0;
        check("R5 valid after last sample", out_valid, 1);

        // R4/R7: idle with changing inputs and coefficients: outputs hold
        begin
            longint hi, hq;
            @(negedge clk);
            hi = out_i; hq = out_q;
            coef_a0 = 18'd3; coef_b1 = 18'd200000;
            idle(5);
            check("R4 out_i hold", out_i, hi);
            check("R4 out_q hold", out_q, hq);
            check("R7 idle coef keeps out_i", out_i, mi);
        end

        // R7: slow filter with new coefficients takes effect on next sample
        coef_a0 = 18'd8192; coef_b1 = 18'd122880;
        for (int k = 0; k < 10; k++) begin
            drive(-5000 + k * 700, 7000, -7000);
            idle(k % 3);
        end
        idle(2);

        // R6 positive saturation: b1 near 2.0
        coef_a0 = 18'd131072; coef_b1 = 18'd262143;
        for (int k = 0; k < 24; k++) drive(8191, 8191, -8192);
        idle(2);
        check("R6 out_i at max", out_i, YMAX);
        check("R6 out_q at min", out_q, YMIN);

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run out_i", out_i, 0);
        check("R1 mid-run out_q", out_q, 0);
        check("R1 mid-run out_valid", out_valid, 0);
        rst = 1'b0; mi = 0; mq = 0;

        // Negative saturation on the in-phase path
        for (int k = 0; k < 24; k++) drive(-8192, 8191, 8191);
        idle(2);
        check("R6 out_i at min", out_i, YMIN);
        check("R6 out_q at min", out_q, YMIN);

        check("R5 all results seen", exp_q_i.size(), 0);
        finish_run();
    end
endmodule